// File: doc/BRIEF.md
# Grouped DMA Channel Priority Arbiter

This block picks the next DMA channel to service out of sixteen request sources. Channels are arranged in four groups of four. Selection takes two steps: first the group with the highest group priority among groups holding a pending request, then, inside that group, the pending channel with the highest channel priority. A channel becomes pending through a one-cycle software start pulse, which the block remembers until the channel is granted. A hardware request line also makes a channel pending, but only while that channel's enable bit is set.

Arbitration runs only in cycles where the transfer engine reports idle. The outcome is registered and shown for exactly one cycle. It is either a grant strobe with a channel number, or one of two error flags. Priorities are expected to be unique. Two groups sharing a group priority, or two channels of the winning group sharing a channel priority, are reported as configuration errors. No tie is broken silently, no grant is made for that attempt, and no channel number is attached to the error.

Top module: `dma_grp_arbiter`

## Requirements
- R1: With `rst` high, all outputs are 0 on the next clock edge, and software starts remembered before reset are discarded.
- R2: Channel c is pending when its start pulse is high this cycle, or its start was remembered and not yet granted, or `hw_req_i[c]` and `hw_en_i[c]` are both high. A hardware request with its enable low has no effect.
- R3: Group g owns channels 4g to 4g+3, and its priority is `grp_prio_i[2g+1:2g]`, with 3 the highest. The winning group is the highest-priority group holding a pending channel.
- R4: Channel c's priority is `ch_prio_i[2c+1:2c]`, with 3 the highest. Within the winning group the highest-priority pending channel is granted. `grant_ch_o` carries 4·group + local index.
- R5: An attempt happens on a clock edge where `idle_i` is high and at least one channel is pending. Its result appears on the outputs after that edge and lasts one cycle. With `idle_i` low, all outputs are 0 after the edge and pending software starts are kept.
- R6: If any two of the four group priorities are equal in an attempt, `grp_err_o` pulses and no grant is made.
- R7: If the group priorities are unique but two channels of the winning group share a priority, `ch_err_o` pulses and no grant is made. Duplicates inside groups that do not win are ignored.
- R8: `grp_err_o` and `ch_err_o` are never high together, and neither is high together with `grant_valid_o`.
- R9: A granted software start is cleared. A hardware request stays pending while its line and enable are held, so it is granted again in every idle cycle in which it still wins.
- R10: With nothing pending, an idle cycle produces no grant and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | Transfer engine idle; enables arbitration |
| sw_start_i | input | 16 | One-cycle software start pulses, one per channel |
| hw_req_i | input | 16 | Peripheral request lines, one per channel |
| hw_en_i | input | 16 | Per-channel hardware request enable |
| ch_prio_i | input | 32 | Channel priority, 2 bits per channel |
| grp_prio_i | input | 8 | Group priority, 2 bits per group |
| grant_valid_o | output | 1 | One-cycle strobe: a channel was selected |
| grant_ch_o | output | 4 | Selected channel number |
| grp_err_o | output | 1 | One-cycle flag: duplicate group priority |
| ch_err_o | output | 1 | One-cycle flag: duplicate channel priority in the winning group |

## Verification
The hardest case to reach is a channel priority error that depends on which group wins. The duplicate has to sit in the group that is selected, while an identical duplicate in a losing group must stay silent. The stimulus therefore leaves a duplicate in one group, first raises a request in a higher group to show that no flag appears, and then raises a request only in the faulty group. A long pseudo-random sweep then varies group rotations, channel rotations, injected duplicates, idle gaps and mixed software and hardware requests. Every cycle is compared against an arithmetic model of the selection rules.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int unsigned DEF_NUM_GRP    = 4;
  localparam int unsigned DEF_CH_PER_GRP = 4;
  localparam int unsigned DEF_PRIO_W     = 2;

  // Outcome of one arbitration attempt
  typedef struct packed {
    logic grant;
    logic grp_err;
    logic ch_err;
  } arb_flags_t;

endpackage

// File: rtl/dma_arb_prio_pick.sv
module dma_arb_prio_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned PW = 2,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]    valid_i,
  input  logic [N*PW-1:0] prio_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic          dup_o
);

  logic [PW-1:0] best;

  // Highest priority among the valid entries
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (valid_i[i] && (!found_o || prio_i[i*PW +: PW] > best)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = prio_i[i*PW +: PW];
      end
    end
  end

  // Pairwise equality over every entry, valid or not
  logic [N-1:0] row_dup;
  for (genvar i = 0; i < int'(N); i++) begin : g_row
    logic [N-1:0] eq;
    for (genvar j = 0; j < int'(N); j++) begin : g_col
      if (j > i) begin : g_cmp
        assign eq[j] = (prio_i[i*PW +: PW] == prio_i[j*PW +: PW]);
      end else begin : g_none
        assign eq[j] = 1'b0;
      end
    end
    assign row_dup[i] = |eq;
  end
  assign dup_o = |row_dup;

  AST_PICK_VALID: assert property (@(posedge clk) disable iff (rst)
    found_o |-> valid_i[idx_o]);                                   // R4
  AST_PICK_NONE: assert property (@(posedge clk) disable iff (rst)
    (valid_i == '0) |-> !found_o);                                 // R10

endmodule

// File: rtl/dma_arb_req.sv
module dma_arb_req #(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] sw_start_i,
  input  logic [NUM_CH-1:0] hw_req_i,
  input  logic [NUM_CH-1:0] hw_en_i,
  input  logic              grant_fire_i,
  input  logic [CH_W-1:0]   grant_ch_i,
  output logic [NUM_CH-1:0] pend_o
);

  logic [NUM_CH-1:0] sw_pend_q;
  logic [NUM_CH-1:0] grant_mask;

  assign grant_mask = grant_fire_i ? (NUM_CH'(1) << grant_ch_i) : '0;
  assign pend_o     = sw_pend_q | sw_start_i | (hw_req_i & hw_en_i);

  always_ff @(posedge clk) begin
    if (rst) sw_pend_q <= '0;
    else     sw_pend_q <= (sw_pend_q | sw_start_i) & ~grant_mask;
  end

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (grant_fire_i && !sw_start_i[grant_ch_i]) |=> !sw_pend_q[$past(grant_ch_i)]); // R9

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_hold
    AST_SW_HOLD: assert property (@(posedge clk) disable iff (rst)
      (sw_pend_q[c] && !(grant_fire_i && grant_ch_i == CH_W'(c))) |=> sw_pend_q[c]); // R5
  end

endmodule

// File: rtl/dma_grp_arbiter.sv
module dma_grp_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_GRP    = DEF_NUM_GRP,
  parameter int unsigned CH_PER_GRP = DEF_CH_PER_GRP,
  parameter int unsigned PRIO_W     = DEF_PRIO_W,
  localparam int unsigned NUM_CH    = NUM_GRP * CH_PER_GRP,
  localparam int unsigned CH_W      = $clog2(NUM_CH),
  localparam int unsigned GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int unsigned LOC_W     = (CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     idle_i,
  input  logic [NUM_CH-1:0]        sw_start_i,
  input  logic [NUM_CH-1:0]        hw_req_i,
  input  logic [NUM_CH-1:0]        hw_en_i,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio_i,
  input  logic [NUM_GRP*PRIO_W-1:0] grp_prio_i,
  output logic                     grant_valid_o,
  output logic [CH_W-1:0]          grant_ch_o,
  output logic                     grp_err_o,
  output logic                     ch_err_o
);

  logic [NUM_CH-1:0]  pend_w;
  logic [NUM_GRP-1:0] grp_active;
  logic               g_found, g_dup, c_found, c_dup;
  logic [GRP_W-1:0]   g_idx;
  logic [LOC_W-1:0]   c_idx;
  logic [CH_PER_GRP-1:0]        win_pend;
  logic [CH_PER_GRP*PRIO_W-1:0] win_prio;
  logic               attempt;
  arb_flags_t         nxt;
  logic [CH_W-1:0]    grant_ch_n;

  dma_arb_req #(.NUM_CH(NUM_CH)) u_req (
    .clk          (clk),
    .rst          (rst),
    .sw_start_i   (sw_start_i),
    .hw_req_i     (hw_req_i),
    .hw_en_i      (hw_en_i),
    .grant_fire_i (nxt.grant),
    .grant_ch_i   (grant_ch_n),
    .pend_o       (pend_w)
  );

  for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_act
    assign grp_active[g] = |pend_w[g*CH_PER_GRP +: CH_PER_GRP];
  end

  // Level one: group selection
  dma_arb_prio_pick #(.N(NUM_GRP), .PW(PRIO_W)) u_grp_pick (
    .clk     (clk),
    .rst     (rst),
    .valid_i (grp_active),
    .prio_i  (grp_prio_i),
    .found_o (g_found),
    .idx_o   (g_idx),
    .dup_o   (g_dup)
  );

  assign win_pend = pend_w[int'(g_idx)*CH_PER_GRP +: CH_PER_GRP];
  assign win_prio = ch_prio_i[int'(g_idx)*CH_PER_GRP*PRIO_W +: CH_PER_GRP*PRIO_W];

  // Level two: channel selection inside the winning group
  dma_arb_prio_pick #(.N(CH_PER_GRP), .PW(PRIO_W)) u_ch_pick (
    .clk     (clk),
    .rst     (rst),
    .valid_i (win_pend),
    .prio_i  (win_prio),
    .found_o (c_found),
    .idx_o   (c_idx),
    .dup_o   (c_dup)
  );

  assign attempt    = idle_i && g_found;
  assign grant_ch_n = CH_W'(int'(g_idx) * int'(CH_PER_GRP) + int'(c_idx));

  always_comb begin
    nxt.grp_err = attempt && g_dup;
    nxt.ch_err  = attempt && !g_dup && c_dup;
    nxt.grant   = attempt && !g_dup && !c_dup && c_found;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid_o <= 1'b0;
      grant_ch_o    <= '0;
      grp_err_o     <= 1'b0;
      ch_err_o      <= 1'b0;
    end else begin
      grant_valid_o <= nxt.grant;
      grant_ch_o    <= nxt.grant ? grant_ch_n : '0;
      grp_err_o     <= nxt.grp_err;
      ch_err_o      <= nxt.ch_err;
    end
  end

  AST_GRANT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (grant_valid_o || grp_err_o || ch_err_o) |-> $past(idle_i));          // R5
  AST_GRPERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    grp_err_o |-> (!ch_err_o && !grant_valid_o));                          // R8
  AST_CHERR_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    ch_err_o |-> !grant_valid_o);                                          // R7
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
    nxt.grant |-> pend_w[grant_ch_n]);                                     // R2
  AST_QUIET_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (pend_w == '0) |=> !(grant_valid_o || grp_err_o || ch_err_o));         // R10

endmodule

// File: tb/dma_grp_arbiter_tb.sv
module dma_grp_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int C = 4;
  localparam int N = G * C;

  logic clk = 1'b0;
  logic rst;
  logic idle;
  logic [N-1:0]   sw_start, hw_req, hw_en;
  logic [2*N-1:0] ch_prio;
  logic [2*G-1:0] grp_prio;
  logic       grant_valid, grp_err, ch_err;
  logic [3:0] grant_ch;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_grp_arbiter dut_i (
    .clk(clk), .rst(rst), .idle_i(idle),
    .sw_start_i(sw_start), .hw_req_i(hw_req), .hw_en_i(hw_en),
    .ch_prio_i(ch_prio), .grp_prio_i(grp_prio),
    .grant_valid_o(grant_valid), .grant_ch_o(grant_ch),
    .grp_err_o(grp_err), .ch_err_o(ch_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [N-1:0] m_swp;
  logic e_v, e_ge, e_ce;
  logic [3:0] e_ch;

  // Reference model of one arbitration step, built from the requirements
  task automatic predict();
    logic [N-1:0] p;
    int bg, bp, bc, bcp;
    logic gd, cd;
    p = m_swp | sw_start | (hw_req & hw_en);
    e_v = 0; e_ge = 0; e_ce = 0; e_ch = 0;
    if (idle && p != 0) begin
      gd = 0;
      for (int i = 0; i < G; i++)
        for (int j = i + 1; j < G; j++)
          if (grp_prio[2*i +: 2] == grp_prio[2*j +: 2]) gd = 1;
      if (gd) e_ge = 1;
      else begin
        bg = 0; bp = -1;
        for (int g = 0; g < G; g++)
          if (p[C*g +: C] != 0 && int'(grp_prio[2*g +: 2]) > bp) begin
            bp = int'(grp_prio[2*g +: 2]); bg = g;
          end
        cd = 0;
        for (int i = 0; i < C; i++)
          for (int j = i + 1; j < C; j++)
            if (ch_prio[2*(bg*C+i) +: 2] == ch_prio[2*(bg*C+j) +: 2]) cd = 1;
        if (cd) e_ce = 1;
        else begin
          bc = 0; bcp = -1;
          for (int i = 0; i < C; i++)
            if (p[bg*C+i] && int'(ch_prio[2*(bg*C+i) +: 2]) > bcp) begin
              bcp = int'(ch_prio[2*(bg*C+i) +: 2]); bc = i;
            end
          e_v = 1; e_ch = 4'(bg*C + bc);
        end
      end
    end
    m_swp = (m_swp | sw_start) & ~(e_v ? (N'(1) << e_ch) : N'(0));
  endtask

  task automatic cycle(input string tag);
    predict();
    @(negedge clk);
    n_cmp++;
    if (grant_valid !== e_v || grp_err !== e_ge || ch_err !== e_ce ||
        (e_v && grant_ch !== e_ch)) begin
      n_bad++;
      $display("FAIL %s: got v=%b ch=%0d ge=%b ce=%b, expected v=%b ch=%0d ge=%b ce=%b",
               tag, grant_valid, grant_ch, grp_err, ch_err, e_v, e_ch, e_ge, e_ce);
    end
    sw_start = '0;
  endtask

  function automatic logic [7:0] perm(input int k, input bit rev);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) r[2*i +: 2] = 2'(rev ? (3 - i + k) : (i + k));
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst = 1; idle = 0; sw_start = '0; hw_req = '0; hw_en = '0;
    grp_prio = perm(0, 0); ch_prio = {4{perm(0, 0)}};
    m_swp = '0;
    @(negedge clk);
    sw_start[6] = 1;            // remembered start, must be wiped by reset
    @(negedge clk); sw_start = '0;
    @(negedge clk);
    n_cmp++;
    if (grant_valid !== 0 || grp_err !== 0 || ch_err !== 0 || grant_ch !== 0) begin
      n_bad++; $display("FAIL R1: got outputs nonzero, expected all 0");
    end
    rst = 0;
    idle = 1;
    cycle("R1 start dropped by reset");

    // R2: hardware requests gated by enable
    hw_req = '1; cycle("R2 disabled hw ignored"); cycle("R2 disabled hw ignored");
    hw_en[5] = 1; cycle("R2 enabled hw ch5");
    hw_req = '0; hw_en = '1;

    // R3: group order
    hw_req[1] = 1; hw_req[9] = 1; cycle("R3 group2 over group0");
    grp_prio = 8'b00_10_01_11; cycle("R3 group0 raised");
    grp_prio = perm(0, 0); hw_req = '0;

    // R4: channel order within group
    hw_req[8] = 1; hw_req[10] = 1; cycle("R4 higher channel prio");
    ch_prio[2*8 +: 8] = perm(0, 1); cycle("R4 reversed group prio");
    ch_prio = {4{perm(0, 0)}}; hw_req = '0;

    // R5 / R9: starts held while busy, then granted once
    idle = 0; sw_start[3] = 1; cycle("R5 busy no grant");
    cycle("R5 busy no grant"); cycle("R5 busy no grant");
    idle = 1; cycle("R9 sw start granted"); cycle("R9 sw start cleared");
    hw_req[7] = 1;
    cycle("R9 hw held regrant"); cycle("R9 hw held regrant"); cycle("R9 hw held regrant");
    hw_req = '0; cycle("R10 nothing pending");

    // R6: duplicate group priority
    grp_prio = 8'b11_01_01_00; hw_req[0] = 1; cycle("R6 dup group prio");
    grp_prio = perm(0, 0); hw_req = '0;

    // R7: duplicate channel prio only matters in winning group
    ch_prio[2*4 +: 8] = 8'b00_00_10_11;
    hw_req[12] = 1; hw_req[5] = 1; cycle("R7 dup in losing group ignored");
    hw_req = '0; hw_req[5] = 1; cycle("R7 dup in winning group");
    // R8: both errors present
    grp_prio = 8'b10_10_01_00; cycle("R8 group error wins");
    grp_prio = perm(0, 0); ch_prio = {4{perm(0, 0)}}; hw_req = '0;
    cycle("R10 idle quiet");

    // R4 / R3: every channel alone under every group rotation
    for (int k = 0; k < 4; k++) begin
      grp_prio = perm(k, 0);
      ch_prio  = {perm(k, 1), perm(k + 1, 0), perm(k + 2, 1), perm(k + 3, 0)};
      for (int c = 0; c < N; c++) begin
        hw_req = '0; hw_req[c] = 1;
        cycle("R4 single channel sweep");
      end
    end
    hw_req = '0;

    // Pseudo-random sweep across all rules
    r = 32'h1357_9bdf;
    for (int t = 0; t < 6000; t++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      if (t % 64 == 0) begin
        grp_prio = perm(int'(r[1:0]), r[2]);
        for (int g = 0; g < G; g++) ch_prio[8*g +: 8] = perm(int'(r[4+2*g +: 2]), r[12+g]);
        if (r[18:16] == 0) grp_prio[1:0] = grp_prio[3:2];
        if (r[21:19] == 0) ch_prio[8*int'(r[23:22]) +: 2] = ch_prio[8*int'(r[23:22]) + 2 +: 2];
      end
      idle     = (r[27:25] != 0);
      hw_en    = r[15:0] | r[31:16];
      hw_req   = r[31:16] & r[23:8] & {r[7:0], r[15:8]};
      sw_start = (r[30:28] == 0) ? (N'(1) << r[3:0]) : '0;
      cycle("R2 R3 R4 R6 R7 R9 random");
    end
    idle = 0; hw_req = '0;
    cycle("R5 final idle low");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule